// File: doc/BRIEF.md
# Maintenance Panel Run/Halt Command Sequencer

This block sits behind the RUN and HALT switches of a maintenance panel. Each switch input is synchronized and debounced. A single-action discriminator then turns one press into exactly one pulse, however long the switch is held. That pulse starts one write transaction on a shared system bus. The write carries the halt or run command word to the CPU control register.

The sequencer raises a bus request and waits for the grant. It then drives the control-register address and the selected command word until the CPU answers with DONE or QUIT. It finishes with a two-edge completion handshake: a sequence-complete flag rises and then falls. It also produces a one-cycle address-done pulse when the answer was DONE, and lights a done lamp that stays lit until master reset. Afterwards it is quiescent, with all bus outputs low, until the next switch closure. A press that arrives during a transaction is dropped. The address and the two command encodings are parameters.

Top module: `panel_cmd_seq`

## Requirements
- R1: While and after synchronous reset (`rst` high), every output is low, including `done_lamp`.
- R2: A switch level must stay stable for `DEB_CYCLES` consecutive synchronized clock cycles before it counts; a shorter glitch starts no transaction.
- R3: One press starts exactly one transaction; holding the switch past completion, or releasing it, starts no further transaction.
- R4: `bus_req` rises after a press and stays high until `bus_gnt` is sampled high; until then `bus_addr_en` is low and `bus_addr`/`bus_data` are zero.
- R5: On the cycle after the grant is sampled, `bus_req` is low, `bus_addr_en` is high, `bus_addr` equals `CTRL_ADDR` and `bus_data` equals `HALT_WORD` (halt press) or `RUN_WORD` (run press); from press to completion exactly the matching one of `halt_sel`/`run_sel` is high.
- R6: If both switches qualify in the same cycle, the halt command wins.
- R7: When `cpu_done` or `cpu_quit` is sampled high while the address is driven, the next cycle shows `seq_cmpl` high and `bus_addr_en`, `bus_addr`, `bus_data`, `halt_sel`, `run_sel` all low.
- R8: `seq_cmpl` is high for exactly one cycle, after which the block is idle.
- R9: `addr_done` pulses for exactly the `seq_cmpl` cycle when the completion was DONE, and stays low when it was QUIT.
- R10: `done_lamp` goes high with `seq_cmpl` and stays high through later transactions until `rst`.
- R11: A switch press during a transaction is ignored, and `cpu_done`/`cpu_quit` that arrive before the address is driven have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| sw_run_raw | input | 1 | Raw RUN switch level |
| sw_halt_raw | input | 1 | Raw HALT switch level |
| bus_gnt | input | 1 | Bus access grant |
| cpu_done | input | 1 | CPU completion response |
| cpu_quit | input | 1 | CPU abort response |
| bus_req | output | 1 | Bus access request |
| bus_addr_en | output | 1 | Address and data lines are driven |
| bus_addr | output | AW | Address lines (control-register address) |
| bus_data | output | DW | Data lines (command word) |
| halt_sel | output | 1 | Halt command selected |
| run_sel | output | 1 | Run command selected |
| seq_cmpl | output | 1 | Sequence-complete flag, one cycle |
| addr_done | output | 1 | Address-done pulse on DONE |
| done_lamp | output | 1 | Latched done indicator |

## Verification
The hardest situation to reach from the ports is a second press, or a stray CPU response, that lands while a transaction is still waiting for grant. The debounced pulse has to arrive inside the request window. The stimulus gets there by holding the grant back for many cycles after a RUN press, closing HALT for longer than the debounce window, and pulsing DONE during the wait. It then confirms that the run word is still the one written, that no completion flag appeared, and that nothing retriggers after release.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_DRIVE = 2'd2,
    ST_CMPL  = 2'd3
  } seq_state_t;

  localparam int NUM_SW = 2;
  localparam int SW_RUN = 0;
  localparam int SW_HALT = 1;
endpackage

// File: rtl/press_discrim.sv
module press_discrim #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_raw,
  output logic press_pulse
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   stable_q;
  logic [CW-1:0]          cnt_q;
  logic                   sw_s;

  assign sw_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '0;
      stable_q    <= 1'b0;
      cnt_q       <= '0;
      press_pulse <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], sw_raw};
      press_pulse <= 1'b0;
      if (sw_s != stable_q) begin
        if (cnt_q == CW'(DEB_CYCLES - 1)) begin
          stable_q    <= sw_s;
          cnt_q       <= '0;
          press_pulse <= sw_s;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R3: a press yields a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse);
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import panel_cmd_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'hFF00,
  parameter logic [DW-1:0] HALT_WORD = 16'h0001,
  parameter logic [DW-1:0] RUN_WORD  = 16'h0002
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt_press,
  input  logic          run_press,
  input  logic          bus_gnt,
  input  logic          cpu_done,
  input  logic          cpu_quit,
  output logic          bus_req,
  output logic          bus_addr_en,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          halt_sel,
  output logic          run_sel,
  output logic          seq_cmpl,
  output logic          addr_done,
  output logic          done_lamp
);
  seq_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bus_req     <= 1'b0;
      bus_addr_en <= 1'b0;
      bus_addr    <= '0;
      bus_data    <= '0;
      halt_sel    <= 1'b0;
      run_sel     <= 1'b0;
      seq_cmpl    <= 1'b0;
      addr_done   <= 1'b0;
      done_lamp   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (halt_press) begin
            halt_sel <= 1'b1;
            bus_req  <= 1'b1;
            state_q  <= ST_REQ;
          end else if (run_press) begin
            run_sel <= 1'b1;
            bus_req <= 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            bus_req     <= 1'b0;
            bus_addr_en <= 1'b1;
            bus_addr    <= CTRL_ADDR;
            bus_data    <= halt_sel ? HALT_WORD : RUN_WORD;
            state_q     <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          if (cpu_done || cpu_quit) begin
            bus_addr_en <= 1'b0;
            bus_addr    <= '0;
            bus_data    <= '0;
            halt_sel    <= 1'b0;
            run_sel     <= 1'b0;
            seq_cmpl    <= 1'b1;
            addr_done   <= cpu_done;
            done_lamp   <= 1'b1;
            state_q     <= ST_CMPL;
          end
        end
        default: begin
          seq_cmpl  <= 1'b0;
          addr_done <= 1'b0;
          state_q   <= ST_IDLE;
        end
      endcase
    end
  end

  // R5: never both command selects
  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halt_sel, run_sel}));
  // R4: no driving while still requesting
  a_r4_req_no_drive: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !bus_addr_en);
  // R7: response while driving releases the lines next cycle
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_en && (cpu_done || cpu_quit)) |=> (seq_cmpl && !bus_addr_en));
  // R8: completion flag lasts one cycle
  a_r8_cmpl_one_cycle: assert property (@(posedge clk) disable iff (rst)
    seq_cmpl |=> !seq_cmpl);
  // R9: address-done only alongside completion
  a_r9_adone_with_cmpl: assert property (@(posedge clk) disable iff (rst)
    addr_done |-> seq_cmpl);
  // R10: lamp is sticky until reset
  a_r10_lamp_sticky: assert property (@(posedge clk) disable iff (rst)
    done_lamp |=> done_lamp);
endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq
  import panel_cmd_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            DW          = 16,
  parameter logic [AW-1:0] CTRL_ADDR   = 16'hFF00,
  parameter logic [DW-1:0] HALT_WORD   = 16'h0001,
  parameter logic [DW-1:0] RUN_WORD    = 16'h0002,
  parameter int            SYNC_STAGES = 2,
  parameter int            DEB_CYCLES  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_run_raw,
  input  logic          sw_halt_raw,
  input  logic          bus_gnt,
  input  logic          cpu_done,
  input  logic          cpu_quit,
  output logic          bus_req,
  output logic          bus_addr_en,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          halt_sel,
  output logic          run_sel,
  output logic          seq_cmpl,
  output logic          addr_done,
  output logic          done_lamp
);
  logic [NUM_SW-1:0] sw_raw;
  logic [NUM_SW-1:0] sw_pulse;

  assign sw_raw[SW_RUN]  = sw_run_raw;
  assign sw_raw[SW_HALT] = sw_halt_raw;

  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    press_discrim #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES)
    ) u_discrim (
      .clk        (clk),
      .rst        (rst),
      .sw_raw     (sw_raw[g]),
      .press_pulse(sw_pulse[g])
    );
  end

  cmd_seq_fsm #(
    .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
    .HALT_WORD(HALT_WORD), .RUN_WORD(RUN_WORD)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .halt_press (sw_pulse[SW_HALT]),
    .run_press  (sw_pulse[SW_RUN]),
    .bus_gnt    (bus_gnt),
    .cpu_done   (cpu_done),
    .cpu_quit   (cpu_quit),
    .bus_req    (bus_req),
    .bus_addr_en(bus_addr_en),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .halt_sel   (halt_sel),
    .run_sel    (run_sel),
    .seq_cmpl   (seq_cmpl),
    .addr_done  (addr_done),
    .done_lamp  (done_lamp)
  );
endmodule

// File: tb/panel_cmd_seq_bench.sv
module panel_cmd_seq_bench;
  localparam int            AW    = 16;
  localparam int            DW    = 16;
  localparam logic [15:0]   CADDR = 16'hFF00;
  localparam logic [15:0]   HWORD = 16'h0001;
  localparam logic [15:0]   RWORD = 16'h0002;
  localparam int            DEB   = 4;

  // fields: [7] halt press, [6] quit response, [5:3] grant delay, [2:0] response delay
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 3'd0, 3'd0},
    {1'b0, 1'b0, 3'd2, 3'd1},
    {1'b1, 1'b1, 3'd5, 3'd3},
    {1'b0, 1'b1, 3'd1, 3'd0},
    {1'b1, 1'b0, 3'd7, 3'd7},
    {1'b0, 1'b0, 3'd3, 3'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_run_raw = 1'b0, sw_halt_raw = 1'b0;
  logic bus_gnt = 1'b0, cpu_done = 1'b0, cpu_quit = 1'b0;
  logic bus_req, bus_addr_en, halt_sel, run_sel, seq_cmpl, addr_done, done_lamp;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  panel_cmd_seq #(
    .AW(AW), .DW(DW), .CTRL_ADDR(CADDR), .HALT_WORD(HWORD),
    .RUN_WORD(RWORD), .SYNC_STAGES(2), .DEB_CYCLES(DEB)
  ) u_panel_cmd_seq (
    .clk(clk), .rst(rst), .sw_run_raw(sw_run_raw), .sw_halt_raw(sw_halt_raw),
    .bus_gnt(bus_gnt), .cpu_done(cpu_done), .cpu_quit(cpu_quit),
    .bus_req(bus_req), .bus_addr_en(bus_addr_en), .bus_addr(bus_addr),
    .bus_data(bus_data), .halt_sel(halt_sel), .run_sel(run_sel),
    .seq_cmpl(seq_cmpl), .addr_done(addr_done), .done_lamp(done_lamp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_req(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      tick();
      if (bus_req) seen = 1'b1;
    end
    chk(seen, req, {31'd0, seen}, 1);
  endtask

  task automatic quiet(input int n, input string req);
    bit any = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (bus_req) any = 1'b1;
    end
    chk(!any, req, {31'd0, any}, 0);
  endtask

  // grant, drive, respond, complete; switch levels are left to the caller
  task automatic finish_txn(input bit halt, input bit quit, input int gd, input int dd);
    for (int i = 0; i < gd; i++) begin
      tick();
      chk(bus_req && !bus_addr_en, "R4 request held", {30'd0, bus_req, bus_addr_en}, 2);
    end
    bus_gnt = 1'b1;
    tick();
    bus_gnt = 1'b0;
    chk(!bus_req && bus_addr_en, "R5 drive after grant", {30'd0, bus_req, bus_addr_en}, 1);
    chk(bus_addr == CADDR, "R5 address", 32'(bus_addr), 32'(CADDR));
    chk(bus_data == (halt ? HWORD : RWORD), "R5 command word", 32'(bus_data),
        32'(halt ? HWORD : RWORD));
    for (int i = 0; i < dd; i++) begin
      tick();
      chk(bus_addr_en && !seq_cmpl, "R7 waiting for response", {30'd0, bus_addr_en, seq_cmpl}, 2);
    end
    if (quit) cpu_quit = 1'b1; else cpu_done = 1'b1;
    tick();
    cpu_quit = 1'b0;
    cpu_done = 1'b0;
    chk(seq_cmpl && !bus_addr_en && bus_addr == '0 && bus_data == '0 && !halt_sel && !run_sel,
        "R7 release", {seq_cmpl, bus_addr_en, halt_sel, run_sel, bus_addr[13:0], bus_data[13:0]},
        32'h8000_0000);
    chk(addr_done == !quit, "R9 address-done", {31'd0, addr_done}, {31'd0, !quit});
    chk(done_lamp, "R10 lamp set", {31'd0, done_lamp}, 1);
    tick();
    chk(!seq_cmpl && !addr_done && !bus_req, "R8 one-cycle completion",
        {29'd0, seq_cmpl, addr_done, bus_req}, 0);
  endtask

  initial begin
    repeat (3) tick();
    chk({bus_req, bus_addr_en, halt_sel, run_sel, seq_cmpl, addr_done, done_lamp} == '0 &&
        bus_addr == '0 && bus_data == '0, "R1 reset state",
        {25'd0, bus_req, bus_addr_en, halt_sel, run_sel, seq_cmpl, addr_done, done_lamp}, 0);
    rst = 1'b0;
    tick();
    chk(!done_lamp && !bus_req, "R1 after reset", {30'd0, done_lamp, bus_req}, 0);

    // R2: glitch shorter than the debounce window
    sw_run_raw = 1'b1;
    repeat (2) tick();
    sw_run_raw = 1'b0;
    quiet(20, "R2 glitch ignored");

    // vector table
    foreach (VEC[k]) begin
      if (VEC[k][7]) sw_halt_raw = 1'b1; else sw_run_raw = 1'b1;
      wait_req("R4 request after press");
      chk(halt_sel == VEC[k][7] && run_sel == !VEC[k][7] && bus_addr == '0 && bus_data == '0,
          "R5 select before grant", {30'd0, halt_sel, run_sel}, {30'd0, VEC[k][7], !VEC[k][7]});
      finish_txn(VEC[k][7], VEC[k][6], int'(VEC[k][5:3]), int'(VEC[k][2:0]));
      quiet(12, "R3 held switch no retrigger");
      sw_halt_raw = 1'b0;
      sw_run_raw  = 1'b0;
      quiet(12, "R3 release no retrigger");
    end

    // R6: both switches together
    sw_halt_raw = 1'b1;
    sw_run_raw  = 1'b1;
    wait_req("R6 request");
    chk(halt_sel && !run_sel, "R6 halt priority", {30'd0, halt_sel, run_sel}, 2);
    finish_txn(1'b1, 1'b0, 1, 1);
    sw_halt_raw = 1'b0;
    sw_run_raw  = 1'b0;
    quiet(12, "R3 release after dual press");

    // R11: press and early response during a pending request
    sw_run_raw = 1'b1;
    wait_req("R11 request");
    sw_halt_raw = 1'b1;
    cpu_done = 1'b1;
    tick();
    cpu_done = 1'b0;
    tick();
    chk(!seq_cmpl && bus_req && !bus_addr_en, "R11 early response ignored",
        {29'd0, seq_cmpl, bus_req, bus_addr_en}, 2);
    repeat (15) tick();
    chk(run_sel && !halt_sel, "R11 second press ignored", {30'd0, halt_sel, run_sel}, 1);
    finish_txn(1'b0, 1'b0, 0, 2);
    sw_run_raw  = 1'b0;
    sw_halt_raw = 1'b0;
    quiet(15, "R11 no queued transaction");

    // R10: lamp survives until reset
    chk(done_lamp, "R10 lamp sticky", {31'd0, done_lamp}, 1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    chk(!done_lamp, "R10 lamp cleared by reset", {31'd0, done_lamp}, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule